// File: doc/BRIEF.md
# Gated transmit queue scheduler

This block decides, cycle by cycle, whether one transmit queue may hand a frame to the medium access logic. It keeps a saturating credit count for the queue. Each software enable strobe adds one credit. Each completed walk of the frame list removes one credit. Under an optional expiry policy, a virtual end-of-list marker or the end of the ready window also removes one credit. Frames are eligible only while at least one credit is held.

Two scheduling policies are available. In the as-soon-as-possible policy, a non-zero credit is enough for eligibility. In the gated policy, eligibility also needs an open ready window. Each beacon-alert pulse opens this window and loads it with a microsecond count. Microsecond ticks then count the window down to zero. Under the gated policy, two suppression bits can also stop an enable strobe from adding a credit: one while this queue is empty, the other while the beacon queue is empty. The second bit lets after-beacon traffic be released only behind a beacon. Descriptor fetch and data movement belong to other blocks.

Top module: `txq_gate_sched`

## Requirements
- R1: Under the as-soon-as-possible policy (`cfg_gated`=0), an `enable_stb` pulse with no decrement source raises `credit` by one at the next clock edge.
- R2: A `list_done` pulse lowers `credit` by one at the next clock edge. When `credit` is 0 it stays 0.
- R3: Under the as-soon-as-possible policy, `frame_ok` is 1 exactly when `credit` is non-zero.
- R4: Under the gated policy (`cfg_gated`=1), `frame_ok` is 1 only while `credit` is non-zero and the ready window is open. A `bcn_alert` pulse loads the window with `cfg_ready_us`, and each `us_tick` lowers it by one. A load of 0 leaves the window closed.
- R5: `credit` saturates at 2^CNT_W-1. An increment and a decrement in the same cycle leave it unchanged.
- R6: Under the gated policy with `cfg_hold_self`=1, an `enable_stb` pulse while `q_empty`=1 does not change `credit`. While `q_empty`=0, the pulse does increment it.
- R7: Under the gated policy with `cfg_hold_bcn`=1, an `enable_stb` pulse while `bcn_q_empty`=1 does not change `credit`. Under the as-soon-as-possible policy, both hold bits are ignored.
- R8: `rdy_expired` is 1 for exactly one cycle: the cycle after the `us_tick` edge that takes the ready window from 1 to 0. A `bcn_alert` at that same edge reloads the window instead, and no pulse is produced.
- R9: With `cfg_exp_policy`=1, a `virt_end` pulse lowers `credit` by one at the next edge, and so does a `rdy_expired` cycle. With `cfg_exp_policy`=0, neither one changes `credit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gated | input | 1 | 1 = beacon-alert gated policy, 0 = as soon as possible |
| cfg_hold_self | input | 1 | Suppress increments while this queue is empty (gated only) |
| cfg_hold_bcn | input | 1 | Suppress increments while the beacon queue is empty (gated only) |
| cfg_exp_policy | input | 1 | Virtual end-of-list and window expiry also consume a credit |
| cfg_ready_us | input | RT_W | Ready window length in microseconds |
| enable_stb | input | 1 | Software enable pulse |
| list_done | input | 1 | Frame list walk reached a null link |
| virt_end | input | 1 | Virtual end-of-list reached |
| us_tick | input | 1 | One-cycle microsecond tick |
| bcn_alert | input | 1 | Periodic beacon-alert pulse |
| q_empty | input | 1 | This queue holds no frames |
| bcn_q_empty | input | 1 | Beacon queue holds no frames |
| frame_ok | output | 1 | Queue may schedule a frame |
| credit | output | CNT_W | Current credit count |
| rdy_expired | output | 1 | One-cycle ready window expiry pulse |

## Verification
Credit movement is tested with lone enables, lone list completions, enables and completions in the same cycle, and long enable runs. These patterns separate a correct counter from one that wraps, underflows, or favours one direction when both fire together. The suppression bits are tested with every empty flag set high and low, under both policies. This separates gating that depends on policy from gating that is unconditional. The ready window is tested with a normal length, a zero length, and the expiry policy switched on and off. These patterns pin down the cycle of the expiry pulse and confirm that it consumes a credit only when the expiry policy selects it.

// File: rtl/txq_gate_sched.sv
module txq_gate_sched #(
  parameter int CNT_W = 4,
  parameter int RT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_gated,
  input  logic             cfg_hold_self,
  input  logic             cfg_hold_bcn,
  input  logic             cfg_exp_policy,
  input  logic [RT_W-1:0]  cfg_ready_us,
  input  logic             enable_stb,
  input  logic             list_done,
  input  logic             virt_end,
  input  logic             us_tick,
  input  logic             bcn_alert,
  input  logic             q_empty,
  input  logic             bcn_q_empty,
  output logic             frame_ok,
  output logic [CNT_W-1:0] credit,
  output logic             rdy_expired
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [RT_W-1:0]  RONE = {{(RT_W-1){1'b0}}, 1'b1};

  logic [RT_W-1:0] win_cnt;
  logic            hold, inc, dec, win_open;

  assign hold = cfg_gated & ((cfg_hold_self & q_empty) | (cfg_hold_bcn & bcn_q_empty));
  assign inc  = enable_stb & ~hold;
  assign dec  = list_done | (cfg_exp_policy & (virt_end | rdy_expired));
  assign win_open = (win_cnt != '0);
  assign frame_ok = (credit != '0) & (~cfg_gated | win_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt     <= '0;
      rdy_expired <= 1'b0;
    end else begin
      rdy_expired <= ~bcn_alert & us_tick & (win_cnt == RONE);
      if (bcn_alert)
        win_cnt <= cfg_ready_us;
      else if (us_tick && win_open)
        win_cnt <= win_cnt - RONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      credit <= '0;
    else if (inc && !dec && credit != CMAX)
      credit <= credit + 1'b1;
    else if (dec && !inc && credit != '0)
      credit <= credit - 1'b1;
  end
endmodule

// File: rtl/txq_gate_sched_chk.sv
module txq_gate_sched_chk #(
  parameter int CNT_W = 4,
  parameter int RT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_gated,
  input logic             cfg_hold_self,
  input logic             cfg_exp_policy,
  input logic             enable_stb,
  input logic             list_done,
  input logic             virt_end,
  input logic             q_empty,
  input logic             frame_ok,
  input logic [CNT_W-1:0] credit,
  input logic             rdy_expired
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic no_dec;
  assign no_dec = !list_done && !(cfg_exp_policy && (virt_end || rdy_expired));

  // R1
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_stb && !cfg_gated && no_dec && credit != CMAX) |=> credit == $past(credit) + 1'b1);
  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (list_done && !enable_stb && credit != '0) |=> credit == $past(credit) - 1'b1);
  // R3
  elig_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> credit != '0);
  // R4
  gated_closed_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_expired && cfg_gated) |-> !frame_ok);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (credit == CMAX && no_dec) |=> credit == CMAX);
  // R6
  hold_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_stb && cfg_gated && cfg_hold_self && q_empty && no_dec) |=> $stable(credit));
  // R8
  expiry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_expired |=> !rdy_expired);
endmodule

bind txq_gate_sched txq_gate_sched_chk #(.CNT_W(CNT_W), .RT_W(RT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_gated(cfg_gated), .cfg_hold_self(cfg_hold_self),
  .cfg_exp_policy(cfg_exp_policy), .enable_stb(enable_stb), .list_done(list_done),
  .virt_end(virt_end), .q_empty(q_empty), .frame_ok(frame_ok), .credit(credit),
  .rdy_expired(rdy_expired)
);

// File: tb/txq_gate_sched_test.sv
module txq_gate_sched_test;
  localparam int CNT_W = 4;
  localparam int RT_W  = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_gated = 0, cfg_hold_self = 0, cfg_hold_bcn = 0, cfg_exp_policy = 0;
  logic [RT_W-1:0] cfg_ready_us = '0;
  logic enable_stb = 0, list_done = 0, virt_end = 0, us_tick = 0, bcn_alert = 0;
  logic q_empty = 0, bcn_q_empty = 0;
  logic frame_ok, rdy_expired;
  logic [CNT_W-1:0] credit;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  txq_gate_sched #(.CNT_W(CNT_W), .RT_W(RT_W)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic ld, input logic ve,
                      input logic ut, input logic ba);
    enable_stb = en; list_done = ld; virt_end = ve; us_tick = ut; bcn_alert = ba;
    @(posedge clk); #1;
    enable_stb = 0; list_done = 0; virt_end = 0; us_tick = 0; bcn_alert = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < CMAX + 1; i++) step(0, 1, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R3 reset credit", credit, 0);
    chk("R3 reset frame_ok", frame_ok, 0);
    chk("R8 reset rdy_expired", rdy_expired, 0);
  endtask

  task automatic t_asap_count();
    cfg_gated = 0;
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R1 three enables", credit, 3);
    chk("R3 eligible with credit", frame_ok, 1);
    step(0, 1, 0, 0, 0);
    chk("R2 list done", credit, 2);
    step(1, 1, 0, 0, 0);
    chk("R5 simultaneous inc dec", credit, 2);
    step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    chk("R2 no underflow", credit, 0);
    chk("R3 ineligible at zero", frame_ok, 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < CMAX + 3; i++) step(1, 0, 0, 0, 0);
    chk("R5 saturates", credit, CMAX);
    step(1, 1, 0, 0, 0);
    chk("R5 inc dec at max", credit, CMAX);
    drain();
  endtask

  task automatic t_hold();
    cfg_gated = 1; cfg_hold_self = 1; q_empty = 1;
    step(1, 0, 0, 0, 0);
    chk("R6 held while self empty", credit, 0);
    q_empty = 0;
    step(1, 0, 0, 0, 0);
    chk("R6 counts when self not empty", credit, 1);
    cfg_hold_self = 0; cfg_hold_bcn = 1; bcn_q_empty = 1;
    step(1, 0, 0, 0, 0);
    chk("R7 held while beacon q empty", credit, 1);
    bcn_q_empty = 0;
    step(1, 0, 0, 0, 0);
    chk("R7 counts when beacon q not empty", credit, 2);
    cfg_gated = 0; cfg_hold_self = 1; q_empty = 1; bcn_q_empty = 1;
    step(1, 0, 0, 0, 0);
    chk("R7 hold bits ignored in asap", credit, 3);
    cfg_hold_self = 0; cfg_hold_bcn = 0; q_empty = 0; bcn_q_empty = 0;
    drain();
  endtask

  task automatic t_window();
    cfg_gated = 1; cfg_exp_policy = 0; cfg_ready_us = 8'd3;
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R4 closed before alert", frame_ok, 0);
    step(0, 0, 0, 0, 1);
    chk("R4 open after alert", frame_ok, 1);
    step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
    chk("R4 open with one left", frame_ok, 1);
    chk("R8 no early pulse", rdy_expired, 0);
    step(0, 0, 0, 1, 0);
    chk("R8 pulse after last tick", rdy_expired, 1);
    chk("R4 closed at expiry", frame_ok, 0);
    step(0, 0, 0, 0, 0);
    chk("R8 pulse one cycle", rdy_expired, 0);
    chk("R9 expiry ignored without policy", credit, 2);
    step(0, 0, 1, 0, 0);
    chk("R9 virt end ignored without policy", credit, 2);
    cfg_ready_us = 8'd0;
    step(0, 0, 0, 0, 1);
    chk("R4 zero length stays closed", frame_ok, 0);
    cfg_ready_us = 8'd1;
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 1);
    chk("R8 reload beats expiry", rdy_expired, 0);
    chk("R4 reloaded window open", frame_ok, 1);
  endtask

  task automatic t_exp_policy();
    cfg_exp_policy = 1; cfg_ready_us = 8'd1;
    step(0, 0, 1, 0, 0);
    chk("R9 virt end consumes", credit, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);
    chk("R8 pulse", rdy_expired, 1);
    step(0, 0, 0, 0, 0);
    chk("R9 expiry consumes", credit, 0);
    cfg_exp_policy = 0; cfg_gated = 0;
    chk("R3 asap zero credit", frame_ok, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_asap_count();
    t_saturate();
    t_hold();
    t_window();
    t_exp_policy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule